// File: doc/BRIEF.md
# SECDED Memory Error Collector

This block gathers error reports from a set of ECC-protected endpoints, which may be RAMs or interconnect ECC stages, and presents them to a CPU. A report from an endpoint is a single-bit error that was corrected, a double-bit error that could not be corrected, or a parity detection. Each report carries the failing RAM address and up to two bit positions. For each endpoint the block keeps one correctable and one uncorrectable record. A record holds a saturating pending count and the details of the first error since the record was last cleared.

Software picks an endpoint with a read selector and sees that endpoint's records on the read outputs in the same cycle. A clear strobe with an endpoint index and two type flags empties the chosen records. All pending state is merged into two level interrupts, one for correctable errors and one for uncorrectable errors. Parity detections cannot be corrected, so they count as uncorrectable.

Top module: `ecc_err_collect`

## Requirements
- R1: After reset every count and every captured field is zero and both interrupts are low.
- R2: A report with `ep_vld` high and kind 2'b01 (corrected single-bit) adds one to that endpoint's correctable count, visible on the read port after the next rising edge.
- R3: A report of kind 2'b10 (double-bit) adds one to that endpoint's uncorrectable count.
- R4: A report of kind 2'b11 (parity) adds one to the uncorrectable count and leaves the correctable count unchanged.
- R5: A report with `ep_vld` low, or with kind 2'b00, changes no state.
- R6: The first correctable event after the count was zero captures its address and bit0. Later correctable events leave the captured values unchanged until that record is cleared.
- R7: The first uncorrectable event after the count was zero captures its address, bit0 and bit1. Later events leave them unchanged until that record is cleared.
- R8: Counts saturate at 2^CNT_W-1 and do not wrap.
- R9: `irq_ce` is high exactly when some correctable count is nonzero, and `irq_ue` is high exactly when some uncorrectable count is nonzero.
- R10: A clear (`clr_vld` with `clr_sel`, plus `clr_ce` and/or `clr_ue`) zeroes the flagged records of the selected endpoint on the next edge and leaves every other record untouched.
- R11: A clear and a same-type event on the same endpoint in the same cycle leave a count of 1, holding the new event's details.
- R12: Reports from several endpoints in the same cycle are all recorded.
- R13: The read outputs show the record of endpoint `rd_sel` combinationally. An index of NUM_EP or above reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_vld | input | NUM_EP | Report strobe per endpoint |
| ep_kind | input | 2*NUM_EP | Report kind per endpoint (00 none, 01 single, 10 double, 11 parity) |
| ep_addr | input | NUM_EP*ADDR_W | Failing RAM address per endpoint |
| ep_bit0 | input | NUM_EP*BIT_W | First failing bit position per endpoint |
| ep_bit1 | input | NUM_EP*BIT_W | Second failing bit position per endpoint |
| clr_vld | input | 1 | Clear strobe |
| clr_sel | input | SEL_W | Endpoint to clear |
| clr_ce | input | 1 | Clear the correctable record |
| clr_ue | input | 1 | Clear the uncorrectable record |
| rd_sel | input | SEL_W | Endpoint to read |
| rd_ce_cnt | output | CNT_W | Correctable count |
| rd_ce_addr | output | ADDR_W | Captured correctable address |
| rd_ce_bit | output | BIT_W | Captured correctable bit |
| rd_ue_cnt | output | CNT_W | Uncorrectable count |
| rd_ue_addr | output | ADDR_W | Captured uncorrectable address |
| rd_ue_bit0 | output | BIT_W | Captured uncorrectable first bit |
| rd_ue_bit1 | output | BIT_W | Captured uncorrectable second bit |
| irq_ce | output | 1 | Correctable-error interrupt level |
| irq_ue | output | 1 | Uncorrectable-error interrupt level |

## Verification
The assertions assume that report kinds, addresses and bit fields are driven to known values whenever `ep_vld` is high. They also assume that a fall of an interrupt can only follow a clear strobe, so no other path may reset a record. The stimulus drives every field from defined values at all times, including the unused fields on idle endpoints. Clears are issued only through the `clr_vld` strobe, with indices inside and beyond the endpoint range.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_SEC  = 2'b01,
        EV_DED  = 2'b10,
        EV_PAR  = 2'b11
    } ev_kind_e;

    function automatic logic kind_is_ce(input logic [1:0] k);
        return k == EV_SEC;
    endfunction

    function automatic logic kind_is_ue(input logic [1:0] k);
        return (k == EV_DED) || (k == EV_PAR);
    endfunction

endpackage

// File: rtl/ecc_agg_slot.sv
module ecc_agg_slot
    import ecc_agg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BIT_W  = 6,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_vld,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [BIT_W-1:0]  ev_bit0,
    input  logic [BIT_W-1:0]  ev_bit1,
    input  logic              clr_ce,
    input  logic              clr_ue,
    output logic [CNT_W-1:0]  ce_cnt,
    output logic [ADDR_W-1:0] ce_addr,
    output logic [BIT_W-1:0]  ce_bit,
    output logic [CNT_W-1:0]  ue_cnt,
    output logic [ADDR_W-1:0] ue_addr,
    output logic [BIT_W-1:0]  ue_bit0,
    output logic [BIT_W-1:0]  ue_bit1
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  ce_cnt;
        logic [ADDR_W-1:0] ce_addr;
        logic [BIT_W-1:0]  ce_bit;
        logic [CNT_W-1:0]  ue_cnt;
        logic [ADDR_W-1:0] ue_addr;
        logic [BIT_W-1:0]  ue_bit0;
        logic [BIT_W-1:0]  ue_bit1;
    } slot_t;

    slot_t st_d, st_q;
    logic  hit_ce, hit_ue;

    always_comb begin
        hit_ce = ev_vld && kind_is_ce(ev_kind);
        hit_ue = ev_vld && kind_is_ue(ev_kind);
        st_d   = st_q;
        // a clear is applied first so that a same-cycle event starts a fresh record
        if (clr_ce) begin
            st_d.ce_cnt  = '0;
            st_d.ce_addr = '0;
            st_d.ce_bit  = '0;
        end
        if (clr_ue) begin
            st_d.ue_cnt  = '0;
            st_d.ue_addr = '0;
            st_d.ue_bit0 = '0;
            st_d.ue_bit1 = '0;
        end
        if (hit_ce) begin
            if (st_d.ce_cnt == '0) begin
                st_d.ce_addr = ev_addr;
                st_d.ce_bit  = ev_bit0;
            end
            if (st_d.ce_cnt != CNT_MAX) st_d.ce_cnt = st_d.ce_cnt + 1'b1;
        end
        if (hit_ue) begin
            if (st_d.ue_cnt == '0) begin
                st_d.ue_addr = ev_addr;
                st_d.ue_bit0 = ev_bit0;
                st_d.ue_bit1 = ev_bit1;
            end
            if (st_d.ue_cnt != CNT_MAX) st_d.ue_cnt = st_d.ue_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ce_cnt  = st_q.ce_cnt;
    assign ce_addr = st_q.ce_addr;
    assign ce_bit  = st_q.ce_bit;
    assign ue_cnt  = st_q.ue_cnt;
    assign ue_addr = st_q.ue_addr;
    assign ue_bit0 = st_q.ue_bit0;
    assign ue_bit1 = st_q.ue_bit1;

    AST_CE_INFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_cnt != '0 && !clr_ce) |=> ($stable(ce_addr) && $stable(ce_bit))); // R6
    AST_UE_INFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_cnt != '0 && !clr_ue) |=> ($stable(ue_addr) && $stable(ue_bit0) && $stable(ue_bit1))); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_cnt == CNT_MAX && !clr_ce) |=> (ce_cnt == CNT_MAX)); // R8
    AST_PAR_NOT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && ev_kind == EV_PAR && !clr_ce) |=> $stable(ce_cnt)); // R4
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ev_vld || ev_kind == EV_NONE) && !clr_ce && !clr_ue) |=> ($stable(ce_cnt) && $stable(ue_cnt))); // R5
    AST_CLEAR_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ce && !(ev_vld && ev_kind == EV_SEC)) |=> (ce_cnt == '0)); // R10

endmodule

// File: rtl/ecc_agg_rd_mux.sv
module ecc_agg_rd_mux #(
    parameter int NUM_EP = 4,
    parameter int REC_W  = 8,
    parameter int SEL_W  = 3
) (
    input  logic [NUM_EP*REC_W-1:0] rec_flat,
    input  logic [SEL_W-1:0]        sel,
    output logic [REC_W-1:0]        rec_out
);

    always_comb begin
        rec_out = '0;
        for (int k = 0; k < NUM_EP; k++) begin
            if (sel == SEL_W'(k)) rec_out = rec_flat[k*REC_W +: REC_W];
        end
    end

endmodule

// File: rtl/ecc_agg_irq.sv
module ecc_agg_irq #(
    parameter int NUM_EP = 4,
    parameter int CNT_W  = 4
) (
    input  logic [NUM_EP*CNT_W-1:0] ce_cnts,
    input  logic [NUM_EP*CNT_W-1:0] ue_cnts,
    output logic                    irq_ce,
    output logic                    irq_ue
);

    logic [NUM_EP-1:0] ce_any, ue_any;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_nz
        assign ce_any[g] = |ce_cnts[g*CNT_W +: CNT_W];
        assign ue_any[g] = |ue_cnts[g*CNT_W +: CNT_W];
    end

    assign irq_ce = |ce_any;
    assign irq_ue = |ue_any;

endmodule

// File: rtl/ecc_err_collect.sv
module ecc_err_collect #(
    parameter int NUM_EP = 4,
    parameter int ADDR_W = 10,
    parameter int BIT_W  = 6,
    parameter int CNT_W  = 4,
    parameter int SEL_W  = $clog2(NUM_EP) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EP-1:0]        ep_vld,
    input  logic [2*NUM_EP-1:0]      ep_kind,
    input  logic [NUM_EP*ADDR_W-1:0] ep_addr,
    input  logic [NUM_EP*BIT_W-1:0]  ep_bit0,
    input  logic [NUM_EP*BIT_W-1:0]  ep_bit1,
    input  logic                     clr_vld,
    input  logic [SEL_W-1:0]         clr_sel,
    input  logic                     clr_ce,
    input  logic                     clr_ue,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [CNT_W-1:0]         rd_ce_cnt,
    output logic [ADDR_W-1:0]        rd_ce_addr,
    output logic [BIT_W-1:0]         rd_ce_bit,
    output logic [CNT_W-1:0]         rd_ue_cnt,
    output logic [ADDR_W-1:0]        rd_ue_addr,
    output logic [BIT_W-1:0]         rd_ue_bit0,
    output logic [BIT_W-1:0]         rd_ue_bit1,
    output logic                     irq_ce,
    output logic                     irq_ue
);

    localparam int REC_W = 2*CNT_W + 2*ADDR_W + 3*BIT_W;

    logic [NUM_EP*REC_W-1:0] rec_flat;
    logic [NUM_EP*CNT_W-1:0] ce_cnts, ue_cnts;
    logic [REC_W-1:0]        rec_sel;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic              clr_ce_g, clr_ue_g;
        logic [CNT_W-1:0]  s_ce_cnt, s_ue_cnt;
        logic [ADDR_W-1:0] s_ce_addr, s_ue_addr;
        logic [BIT_W-1:0]  s_ce_bit, s_ue_bit0, s_ue_bit1;

        assign clr_ce_g = clr_vld && clr_ce && (clr_sel == SEL_W'(g));
        assign clr_ue_g = clr_vld && clr_ue && (clr_sel == SEL_W'(g));

        ecc_agg_slot #(
            .ADDR_W (ADDR_W),
            .BIT_W  (BIT_W),
            .CNT_W  (CNT_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_vld  (ep_vld[g]),
            .ev_kind (ep_kind[2*g +: 2]),
            .ev_addr (ep_addr[g*ADDR_W +: ADDR_W]),
            .ev_bit0 (ep_bit0[g*BIT_W +: BIT_W]),
            .ev_bit1 (ep_bit1[g*BIT_W +: BIT_W]),
            .clr_ce  (clr_ce_g),
            .clr_ue  (clr_ue_g),
            .ce_cnt  (s_ce_cnt),
            .ce_addr (s_ce_addr),
            .ce_bit  (s_ce_bit),
            .ue_cnt  (s_ue_cnt),
            .ue_addr (s_ue_addr),
            .ue_bit0 (s_ue_bit0),
            .ue_bit1 (s_ue_bit1)
        );

        assign rec_flat[g*REC_W +: REC_W] =
            {s_ce_cnt, s_ce_addr, s_ce_bit, s_ue_cnt, s_ue_addr, s_ue_bit0, s_ue_bit1};
        assign ce_cnts[g*CNT_W +: CNT_W] = s_ce_cnt;
        assign ue_cnts[g*CNT_W +: CNT_W] = s_ue_cnt;
    end

    ecc_agg_rd_mux #(
        .NUM_EP (NUM_EP),
        .REC_W  (REC_W),
        .SEL_W  (SEL_W)
    ) u_rd_mux (
        .rec_flat (rec_flat),
        .sel      (rd_sel),
        .rec_out  (rec_sel)
    );

    assign {rd_ce_cnt, rd_ce_addr, rd_ce_bit, rd_ue_cnt, rd_ue_addr, rd_ue_bit0, rd_ue_bit1} = rec_sel;

    ecc_agg_irq #(
        .NUM_EP (NUM_EP),
        .CNT_W  (CNT_W)
    ) u_irq (
        .ce_cnts (ce_cnts),
        .ue_cnts (ue_cnts),
        .irq_ce  (irq_ce),
        .irq_ue  (irq_ue)
    );

    AST_IRQ_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ce) |-> $past(|ep_vld)); // R9
    AST_IRQ_UE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ue) |-> $past(|ep_vld)); // R9
    AST_IRQ_CE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_ce) |-> $past(clr_vld && clr_ce)); // R10
    AST_IRQ_UE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_ue) |-> $past(clr_vld && clr_ue)); // R10
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) >= NUM_EP) |-> (rd_ce_cnt == '0 && rd_ue_cnt == '0)); // R13

endmodule

// File: tb/ecc_err_collect_tb.sv
`timescale 1ns/100ps
module ecc_err_collect_tb;

    localparam int NUM_EP = 4;
    localparam int ADDR_W = 10;
    localparam int BIT_W  = 6;
    localparam int CNT_W  = 4;
    localparam int SEL_W  = $clog2(NUM_EP) + 1;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_EP-1:0]        ep_vld = '0;
    logic [2*NUM_EP-1:0]      ep_kind = '0;
    logic [NUM_EP*ADDR_W-1:0] ep_addr = '0;
    logic [NUM_EP*BIT_W-1:0]  ep_bit0 = '0;
    logic [NUM_EP*BIT_W-1:0]  ep_bit1 = '0;
    logic                     clr_vld = 1'b0;
    logic [SEL_W-1:0]         clr_sel = '0;
    logic                     clr_ce = 1'b0;
    logic                     clr_ue = 1'b0;
    logic [SEL_W-1:0]         rd_sel = '0;
    logic [CNT_W-1:0]         rd_ce_cnt, rd_ue_cnt;
    logic [ADDR_W-1:0]        rd_ce_addr, rd_ue_addr;
    logic [BIT_W-1:0]         rd_ce_bit, rd_ue_bit0, rd_ue_bit1;
    logic                     irq_ce, irq_ue;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference records
    int m_ce_cnt[NUM_EP], m_ce_addr[NUM_EP], m_ce_bit[NUM_EP];
    int m_ue_cnt[NUM_EP], m_ue_addr[NUM_EP], m_ue_b0[NUM_EP], m_ue_b1[NUM_EP];

    always #2.5 clk = ~clk;

    ecc_err_collect #(
        .NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .BIT_W(BIT_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ep_vld(ep_vld), .ep_kind(ep_kind), .ep_addr(ep_addr),
        .ep_bit0(ep_bit0), .ep_bit1(ep_bit1), .clr_vld(clr_vld), .clr_sel(clr_sel),
        .clr_ce(clr_ce), .clr_ue(clr_ue), .rd_sel(rd_sel), .rd_ce_cnt(rd_ce_cnt),
        .rd_ce_addr(rd_ce_addr), .rd_ce_bit(rd_ce_bit), .rd_ue_cnt(rd_ue_cnt),
        .rd_ue_addr(rd_ue_addr), .rd_ue_bit0(rd_ue_bit0), .rd_ue_bit1(rd_ue_bit1),
        .irq_ce(irq_ce), .irq_ue(irq_ue)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic set_ev(input int e, input int kind, input int a, input int b0, input int b1);
        ep_vld[e]                  = 1'b1;
        ep_kind[2*e +: 2]          = kind[1:0];
        ep_addr[e*ADDR_W +: ADDR_W] = a[ADDR_W-1:0];
        ep_bit0[e*BIT_W +: BIT_W]  = b0[BIT_W-1:0];
        ep_bit1[e*BIT_W +: BIT_W]  = b1[BIT_W-1:0];
    endtask

    task automatic set_clr(input int e, input bit c, input bit u);
        clr_vld = 1'b1;
        clr_sel = e[SEL_W-1:0];
        clr_ce  = c;
        clr_ue  = u;
    endtask

    task automatic idle_inputs();
        ep_vld = '0; ep_kind = '0; ep_addr = '0; ep_bit0 = '0; ep_bit1 = '0;
        clr_vld = 1'b0; clr_sel = '0; clr_ce = 1'b0; clr_ue = 1'b0;
    endtask

    task automatic model_update();
        for (int e = 0; e < NUM_EP; e++) begin
            int k;
            if (clr_vld && int'(clr_sel) == e && clr_ce) begin
                m_ce_cnt[e] = 0; m_ce_addr[e] = 0; m_ce_bit[e] = 0;
            end
            if (clr_vld && int'(clr_sel) == e && clr_ue) begin
                m_ue_cnt[e] = 0; m_ue_addr[e] = 0; m_ue_b0[e] = 0; m_ue_b1[e] = 0;
            end
            k = ep_vld[e] ? int'(ep_kind[2*e +: 2]) : 0;
            if (k == 1) begin
                if (m_ce_cnt[e] == 0) begin
                    m_ce_addr[e] = int'(ep_addr[e*ADDR_W +: ADDR_W]);
                    m_ce_bit[e]  = int'(ep_bit0[e*BIT_W +: BIT_W]);
                end
                if (m_ce_cnt[e] < CMAX) m_ce_cnt[e]++;
            end else if (k == 2 || k == 3) begin
                if (m_ue_cnt[e] == 0) begin
                    m_ue_addr[e] = int'(ep_addr[e*ADDR_W +: ADDR_W]);
                    m_ue_b0[e]   = int'(ep_bit0[e*BIT_W +: BIT_W]);
                    m_ue_b1[e]   = int'(ep_bit1[e*BIT_W +: BIT_W]);
                end
                if (m_ue_cnt[e] < CMAX) m_ue_cnt[e]++;
            end
        end
    endtask

    task automatic compare_all();
        bit any_ce = 0, any_ue = 0;
        for (int e = 0; e < NUM_EP; e++) begin
            rd_sel = e[SEL_W-1:0];
            #0.2;
            chk("R2", "ce_cnt", int'(rd_ce_cnt), m_ce_cnt[e]);
            chk("R3", "ue_cnt", int'(rd_ue_cnt), m_ue_cnt[e]);
            chk("R6", "ce_addr", int'(rd_ce_addr), m_ce_addr[e]);
            chk("R6", "ce_bit", int'(rd_ce_bit), m_ce_bit[e]);
            chk("R7", "ue_addr", int'(rd_ue_addr), m_ue_addr[e]);
            chk("R7", "ue_bit0", int'(rd_ue_bit0), m_ue_b0[e]);
            chk("R7", "ue_bit1", int'(rd_ue_bit1), m_ue_b1[e]);
            if (m_ce_cnt[e] != 0) any_ce = 1;
            if (m_ue_cnt[e] != 0) any_ue = 1;
        end
        chk("R9", "irq_ce", int'(irq_ce), int'(any_ce));
        chk("R9", "irq_ue", int'(irq_ue), int'(any_ue));
    endtask

    // inputs are set by the caller after a falling edge; this clocks them in and compares
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic peek(input int e);
        rd_sel = e[SEL_W-1:0];
        #0.2;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < NUM_EP; e++) begin
            m_ce_cnt[e] = 0; m_ce_addr[e] = 0; m_ce_bit[e] = 0;
            m_ue_cnt[e] = 0; m_ue_addr[e] = 0; m_ue_b0[e] = 0; m_ue_b1[e] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        peek(0);
        chk("R1", "irq_ce reset", int'(irq_ce), 0);
        chk("R1", "irq_ue reset", int'(irq_ue), 0);
        chk("R1", "ce_cnt reset", int'(rd_ce_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R2 + R6: first corrected error captured
        set_ev(1, 1, 'h55, 7, 0); step();
        peek(1);
        chk("R2", "ep1 ce_cnt", int'(rd_ce_cnt), 1);
        chk("R6", "ep1 ce_addr", int'(rd_ce_addr), 'h55);
        // R6: second event keeps first info
        set_ev(1, 1, 'h2aa, 12, 0); step();
        peek(1);
        chk("R6", "ep1 ce_addr kept", int'(rd_ce_addr), 'h55);
        chk("R6", "ep1 ce_bit kept", int'(rd_ce_bit), 7);

        // R3 + R7: double-bit error
        set_ev(2, 2, 'h101, 3, 9); step();
        set_ev(2, 2, 'h3ff, 1, 2); step();
        peek(2);
        chk("R3", "ep2 ue_cnt", int'(rd_ue_cnt), 2);
        chk("R7", "ep2 ue_bit1 kept", int'(rd_ue_bit1), 9);

        // R4: parity counts as uncorrectable
        set_ev(3, 3, 'h0f0, 20, 0); step();
        peek(3);
        chk("R4", "ep3 ue_cnt parity", int'(rd_ue_cnt), 1);
        chk("R4", "ep3 ce_cnt parity", int'(rd_ce_cnt), 0);
        chk("R4", "irq_ue parity", int'(irq_ue), 1);

        // R5: kind 00 with strobe, and kind set without strobe
        set_ev(0, 0, 'h77, 5, 5); step();
        ep_kind[1:0] = 2'b10; ep_addr[ADDR_W-1:0] = 'h12; step();
        peek(0);
        chk("R5", "ep0 ce_cnt idle", int'(rd_ce_cnt), 0);
        chk("R5", "ep0 ue_cnt idle", int'(rd_ue_cnt), 0);

        // R12: all endpoints in one cycle
        for (int e = 0; e < NUM_EP; e++) set_ev(e, 1, 'h200 + e, e + 1, 0);
        step();
        peek(0); chk("R12", "ep0 ce_cnt", int'(rd_ce_cnt), 1);
        peek(3); chk("R12", "ep3 ce_cnt", int'(rd_ce_cnt), 1);
        peek(1); chk("R12", "ep1 ce_cnt", int'(rd_ce_cnt), 3);

        // R10: clear ep1 correctable only
        set_clr(1, 1, 0); step();
        peek(1);
        chk("R10", "ep1 ce_cnt cleared", int'(rd_ce_cnt), 0);
        chk("R10", "ep1 ce_addr cleared", int'(rd_ce_addr), 0);
        peek(2);
        chk("R10", "ep2 ue untouched", int'(rd_ue_cnt), 2);

        // R11: clear and new event same cycle
        set_clr(2, 0, 1); set_ev(2, 2, 'h0aa, 30, 31); step();
        peek(2);
        chk("R11", "ep2 ue_cnt", int'(rd_ue_cnt), 1);
        chk("R11", "ep2 ue_addr", int'(rd_ue_addr), 'h0aa);

        // R8: saturation
        for (int i = 0; i < CMAX + 4; i++) begin
            set_ev(0, 1, i, 0, 0); step();
        end
        peek(0);
        chk("R8", "ep0 ce_cnt sat", int'(rd_ce_cnt), CMAX);

        // R13: out-of-range read
        rd_sel = SEL_W'(NUM_EP); #0.2;
        chk("R13", "oor ce_cnt", int'(rd_ce_cnt), 0);
        chk("R13", "oor ue_addr", int'(rd_ue_addr), 0);

        // R9: clear everything, interrupts drop
        for (int e = 0; e < NUM_EP; e++) begin
            set_clr(e, 1, 1); step();
        end
        chk("R9", "irq_ce all clear", int'(irq_ce), 0);
        chk("R9", "irq_ue all clear", int'(irq_ue), 0);

        // mixed traffic against the reference
        for (int c = 0; c < 400; c++) begin
            for (int e = 0; e < NUM_EP; e++) begin
                if ($urandom_range(0, 3) == 0)
                    set_ev(e, int'($urandom_range(0, 3)), int'($urandom_range(0, 1023)),
                           int'($urandom_range(0, 63)), int'($urandom_range(0, 63)));
            end
            if ($urandom_range(0, 5) == 0)
                set_clr(int'($urandom_range(0, NUM_EP)), 1'($urandom_range(0, 1)),
                        1'($urandom_range(0, 1)));
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule